// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block turns stack operations and interrupt entry into byte-wide memory cycles for a CPU with 24-bit addresses. It owns the 16-bit stack pointer. It accepts one command at a time: push, pull, software break, coprocessor trap, return from interrupt, or wait for interrupt. It also watches three hardware interrupt lines and services a pending reset vector fetch after power-up. Every memory access goes to bank 0 over a simple request/acknowledge bus, one byte per cycle.

On interrupt entry the block saves the caller's program bank, program counter and status on the stack. It then reads a 16-bit handler address from a fixed vector for the source and reports a redirect with the new PC, a program bank of zero and an adjusted status byte. A return from interrupt restores those values from the stack and reports them on the same redirect outputs. Push and pull results are reported with a one-cycle `done` pulse.

Top module: `stack_irq_seq`

## Requirements
- R1: While reset is held, `sp` reads 0x0100 and `mem_req` and `cmd_ready` are 0. After reset the block reads 0xFFFC and then 0xFFFD. It then pulses `redirect` with `new_pc` = {byte at 0xFFFD, byte at 0xFFFC}, `new_pb` = 0, `new_p` = 0x34 and `int_src` = 0.
- R2: Every bus cycle carries 0x00 in `mem_addr[23:16]`. A raised `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_ack` is seen.
- R3: Push (`cmd_op` = 0) writes at the current `sp` and then decrements `sp` for each byte. When `cmd_wide` = 1 it writes `cmd_wdata[15:8]` first and then `cmd_wdata[7:0]`. When `cmd_wide` = 0 it writes only `cmd_wdata[7:0]`. `done` pulses at the end.
- R4: Pull (`cmd_op` = 1) increments `sp` and then reads, for each byte. When wide, the first byte read is the low half of `pull_data` and the second is the high half. When narrow, `pull_data[15:8]` is 0.
- R5: Interrupt entry writes `cpu_pb`, `cpu_pc[15:8]`, `cpu_pc[7:0]` and `cpu_p` to the stack, in that order. It then reads the vector low byte at V and the high byte at V+1.
- R6: The vector V and the `int_src` code per source are: reset 0xFFFC (0), abort 0xFFE8 (1), NMI 0xFFEA (2), IRQ 0xFFEE (3), break (`cmd_op` = 2) 0xFFE6 (4), coprocessor (`cmd_op` = 3) 0xFFE4 (5).
- R7: After a non-reset entry, `redirect` shows `new_pb` = 0 and `new_p` = the saved status with bit 2 set and bit 3 cleared.
- R8: Pending work is served in the order reset, `abort_req`, `nmi_req`, `irq_req`, command. `irq_req` is not taken while `cpu_p[2]` = 1, and commands proceed normally in that case.
- R9: Return from interrupt (`cmd_op` = 4) pulls status, PC low, PC high and program bank, in that order. It then pulses `redirect` with those values and leaves `sp` where it was before the entry.
- R10: Wait (`cmd_op` = 5) raises `waiting` with no bus cycle and `cmd_ready` = 0. A masked `irq_req` ends the wait with a `done` pulse. An unmasked one starts interrupt entry.
- R11: Op codes 6 and 7 pulse `done` with no bus cycle and no change to `sp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 3 | Operation code |
| cmd_wide | input | 1 | 16-bit push or pull |
| cmd_wdata | input | 16 | Push data |
| cpu_pc | input | 16 | Return PC to save on entry |
| cpu_pb | input | 8 | Program bank to save on entry |
| cpu_p | input | 8 | Status to save; bit 2 masks IRQ |
| irq_req | input | 1 | Maskable interrupt level |
| nmi_req | input | 1 | Non-maskable interrupt level |
| abort_req | input | 1 | Abort interrupt level |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Bus cycle complete |
| mem_rdata | input | 8 | Read byte, valid with ack |
| sp | output | 16 | Stack pointer |
| done | output | 1 | Push, pull, wait or no-op finished |
| pull_data | output | 16 | Pulled value, valid with done |
| redirect | output | 1 | Entry or return finished |
| new_pc | output | 16 | PC to continue from |
| new_pb | output | 8 | Program bank to continue from |
| new_p | output | 8 | Status to continue with |
| int_src | output | 3 | Source code of the entry |
| waiting | output | 1 | Wait state active |

## Verification
Narrow and wide pushes and pulls are interleaved so that byte order and the pointer crossing from 0x0100 into 0x00FF show up separately. A wrong order shows as a swapped value, and a wrong pointer step shows as a wrong address. Break followed by return checks that entry and exit use mirrored orders. Raising abort, NMI and IRQ together exposes the priority order and the per-source vector. A masked IRQ is driven during ordinary commands and during a wait, to separate masking from waking. The bus acknowledge latency rotates over 0, 1 and 2 wait cycles, so that request holding is exercised on every access pattern.

// File: rtl/stack_irq_seq.sv
module stack_irq_seq #(
  parameter logic [15:0] SP_INIT = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic        cmd_wide,
  input  logic [15:0] cmd_wdata,
  input  logic [15:0] cpu_pc,
  input  logic [7:0]  cpu_pb,
  input  logic [7:0]  cpu_p,
  input  logic        irq_req,
  input  logic        nmi_req,
  input  logic        abort_req,
  output logic        mem_req,
  output logic        mem_we,
  output logic [23:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] sp,
  output logic        done,
  output logic [15:0] pull_data,
  output logic        redirect,
  output logic [15:0] new_pc,
  output logic [7:0]  new_pb,
  output logic [7:0]  new_p,
  output logic [2:0]  int_src,
  output logic        waiting
);
  localparam logic [1:0] S_IDLE = 2'd0, S_BUS = 2'd1, S_WAIT = 2'd2;
  localparam logic [2:0] J_PUSH = 3'd0, J_PULL = 3'd1, J_INT = 3'd2, J_RTI = 3'd3, J_NOP = 3'd4;
  localparam logic [2:0] SRC_RST = 3'd0, SRC_ABT = 3'd1, SRC_NMI = 3'd2,
                         SRC_IRQ = 3'd3, SRC_BRK = 3'd4, SRC_COP = 3'd5;
  localparam logic [2:0] OP_PUSH = 3'd0, OP_PULL = 3'd1, OP_BRK = 3'd2,
                         OP_COP = 3'd3, OP_RTI = 3'd4, OP_WAI = 3'd5;
  localparam logic [7:0] P_AFTER_RST = 8'h34;

  logic [1:0]  st;
  logic [2:0]  job, src, step, pend_src;
  logic        wide, rst_pend, fin;
  logic [15:0] s_q, pc_q, dat_q, vec, addr;
  logic [7:0]  pb_q, p_q, wbyte;
  logic [7:0]  rb [4];
  logic        is_wr, is_vec, last;

  wire irq_ok = irq_req & ~cpu_p[2];
  wire pend   = rst_pend | abort_req | nmi_req | irq_ok;

  always_comb begin
    if (rst_pend)       pend_src = SRC_RST;
    else if (abort_req) pend_src = SRC_ABT;
    else if (nmi_req)   pend_src = SRC_NMI;
    else                pend_src = SRC_IRQ;
  end

  always_comb begin
    case (src)
      SRC_ABT: vec = 16'hFFE8;
      SRC_NMI: vec = 16'hFFEA;
      SRC_IRQ: vec = 16'hFFEE;
      SRC_BRK: vec = 16'hFFE6;
      SRC_COP: vec = 16'hFFE4;
      default: vec = 16'hFFFC;
    endcase
  end

  assign is_wr  = (job == J_PUSH) | ((job == J_INT) & ~step[2]);
  assign is_vec = (job == J_INT) & step[2];
  assign addr   = is_vec ? vec + {15'd0, step[0]} : (is_wr ? s_q : s_q + 16'd1);

  always_comb begin
    case (job)
      J_PUSH:  last = (step == 3'd1);
      J_PULL:  last = wide ? (step == 3'd1) : (step == 3'd0);
      J_INT:   last = (step == 3'd5);
      J_RTI:   last = (step == 3'd3);
      default: last = 1'b1;
    endcase
  end

  always_comb begin
    wbyte = 8'h00;
    if (job == J_PUSH) wbyte = (step == 3'd0) ? dat_q[15:8] : dat_q[7:0];
    else if (job == J_INT) begin
      case (step[1:0])
        2'd0:    wbyte = pb_q;
        2'd1:    wbyte = pc_q[15:8];
        2'd2:    wbyte = pc_q[7:0];
        default: wbyte = p_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      job      <= J_NOP;
      src      <= SRC_RST;
      step     <= 3'd0;
      wide     <= 1'b0;
      rst_pend <= 1'b1;
      fin      <= 1'b0;
      s_q      <= SP_INIT;
      pc_q     <= 16'h0000;
      pb_q     <= 8'h00;
      p_q      <= 8'h00;
      dat_q    <= 16'h0000;
      for (int i = 0; i < 4; i++) rb[i] <= 8'h00;
    end else begin
      fin <= 1'b0;
      case (st)
        S_IDLE, S_WAIT: begin
          if (pend) begin
            st       <= S_BUS;
            job      <= J_INT;
            src      <= pend_src;
            step     <= rst_pend ? 3'd4 : 3'd0;
            rst_pend <= 1'b0;
            pc_q     <= cpu_pc;
            pb_q     <= cpu_pb;
            p_q      <= cpu_p;
          end else if (st == S_WAIT) begin
            if (irq_req) begin
              st  <= S_IDLE;
              job <= J_NOP;
              fin <= 1'b1;
            end
          end else if (cmd_valid) begin
            step <= 3'd0;
            case (cmd_op)
              OP_PUSH: begin
                st    <= S_BUS;
                job   <= J_PUSH;
                wide  <= cmd_wide;
                dat_q <= cmd_wdata;
                step  <= cmd_wide ? 3'd0 : 3'd1;
              end
              OP_PULL: begin
                st   <= S_BUS;
                job  <= J_PULL;
                wide <= cmd_wide;
              end
              OP_BRK, OP_COP: begin
                st   <= S_BUS;
                job  <= J_INT;
                src  <= (cmd_op == OP_BRK) ? SRC_BRK : SRC_COP;
                pc_q <= cpu_pc;
                pb_q <= cpu_pb;
                p_q  <= cpu_p;
              end
              OP_RTI: begin
                st  <= S_BUS;
                job <= J_RTI;
              end
              OP_WAI: st <= S_WAIT;
              default: begin
                job <= J_NOP;
                fin <= 1'b1;
              end
            endcase
          end
        end
        S_BUS: begin
          if (mem_ack) begin
            if (is_wr)        s_q <= s_q - 16'd1;
            else if (!is_vec) s_q <= s_q + 16'd1;
            if (!is_wr) rb[step[1:0]] <= mem_rdata;
            if (last) begin
              st  <= S_IDLE;
              fin <= 1'b1;
            end else begin
              step <= step + 3'd1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE) & ~pend;
  assign mem_req   = (st == S_BUS);
  assign mem_we    = mem_req & is_wr;
  assign mem_addr  = {8'h00, addr};
  assign mem_wdata = mem_we ? wbyte : 8'h00;
  assign sp        = s_q;
  assign waiting   = (st == S_WAIT);
  assign done      = fin & ((job == J_PUSH) | (job == J_PULL) | (job == J_NOP));
  assign redirect  = fin & ((job == J_INT) | (job == J_RTI));
  assign pull_data = wide ? {rb[1], rb[0]} : {8'h00, rb[0]};
  assign new_pc    = (job == J_RTI) ? {rb[2], rb[1]} : {rb[1], rb[0]};
  assign new_pb    = (job == J_RTI) ? rb[3] : 8'h00;
  assign new_p     = (job == J_RTI) ? rb[0] :
                     (src == SRC_RST) ? P_AFTER_RST : ((p_q | 8'h04) & ~8'h08);
  assign int_src   = src;
endmodule

// File: rtl/stack_irq_seq_chk.sv
module stack_irq_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [23:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [15:0] sp,
  input logic        waiting,
  input logic        cmd_ready
);
  // R2
  bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[23:16] == 8'h00);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> sp == $past(sp) - 16'd1);

  // R3
  write_at_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[15:0] == sp);

  // R10
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !mem_req && !cmd_ready);

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);
endmodule

bind stack_irq_seq stack_irq_seq_chk i_chk (.*);

// File: tb/test_stack_irq_seq.sv
module test_stack_irq_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready, cmd_wide = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_wdata = 16'h0;
  logic [15:0] cpu_pc = 16'h0;
  logic [7:0]  cpu_pb = 8'h0, cpu_p = 8'h04;
  logic        irq_req = 1'b0, nmi_req = 1'b0, abort_req = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = 8'h0;
  logic [15:0] sp, pull_data, new_pc;
  logic        done, redirect, waiting;
  logic [7:0]  new_pb, new_p;
  logic [2:0]  int_src;

  stack_irq_seq i_stack_irq_seq (.*);

  int n_chk = 0, n_fail = 0;
  int lat = 0, wcnt = 0;
  string cur_tag = "R1";
  logic [7:0]  mem [int];
  logic [24:0] expq [$];
  logic [15:0] msp = 16'h0100;

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input int a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (expq.size() == 0) chk({cur_tag, " unexpected bus cycle"}, 1, 0);
      else chk({cur_tag, " R2 bus cycle"}, int'({mem_we, mem_addr[15:0], mem_we ? mem_wdata : 8'h00}), int'(expq[0]));
      chk("R2 bank", int'(mem_addr[23:16]), 0);
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) mem[int'(mem_addr[15:0])] = mem_wdata;
        else mem_rdata = rd(int'(mem_addr[15:0]));
        if (expq.size() > 0) void'(expq.pop_front());
        wcnt = 0;
        lat = (lat + 1) % 3;
      end else begin
        mem_ack = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic e_push(input logic [7:0] b);
    expq.push_back({1'b1, msp, b});
    msp = msp - 16'd1;
  endtask

  task automatic e_pull();
    msp = msp + 16'd1;
    expq.push_back({1'b0, msp, 8'h00});
  endtask

  task automatic e_vec(input logic [15:0] v);
    expq.push_back({1'b0, v, 8'h00});
    expq.push_back({1'b0, v + 16'd1, 8'h00});
  endtask

  task automatic e_entry(input logic [15:0] v);
    e_push(cpu_pb); e_push(cpu_pc[15:8]); e_push(cpu_pc[7:0]); e_push(cpu_p);
    e_vec(v);
  endtask

  task automatic issue(input logic [2:0] op, input logic w, input logic [15:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_wide = w; cmd_wdata = d; cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic wait_fin();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(done || redirect) && n < 2000);
    if (n >= 2000) chk({cur_tag, " timeout"}, 0, 1);
  endtask

  task automatic check_redir(input string r, input logic [15:0] pc, input logic [7:0] pb,
                             input logic [7:0] p, input logic [2:0] s);
    chk({r, " redirect"}, int'(redirect), 1);
    chk({r, " new_pc"}, int'(new_pc), int'(pc));
    chk({r, " new_pb"}, int'(new_pb), int'(pb));
    chk({r, " new_p"}, int'(new_p), int'(p));
    chk({r, " int_src"}, int'(int_src), int'(s));
    chk({r, " sp"}, int'(sp), int'(msp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    mem[16'hFFFC] = 8'h34; mem[16'hFFFD] = 8'h12;
    mem[16'hFFE4] = 8'h40; mem[16'hFFE5] = 8'h80;
    mem[16'hFFE6] = 8'h00; mem[16'hFFE7] = 8'h90;
    mem[16'hFFE8] = 8'h00; mem[16'hFFE9] = 8'hA0;
    mem[16'hFFEA] = 8'h00; mem[16'hFFEB] = 8'hB0;
    mem[16'hFFEE] = 8'h00; mem[16'hFFEF] = 8'hC0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 sp in reset", int'(sp), 16'h0100);
    chk("R1 no req in reset", int'(mem_req), 0);
    chk("R1 not ready in reset", int'(cmd_ready), 0);
    cur_tag = "R1";
    e_vec(16'hFFFC);
    rst_n = 1'b1;
    wait_fin();
    check_redir("R1", 16'h1234, 8'h00, 8'h34, 3'd0);

    // R3 wide push, crossing 0x0100 -> 0x00FF
    cur_tag = "R3";
    e_push(8'hBE); e_push(8'hEF);
    issue(3'd0, 1'b1, 16'hBEEF);
    wait_fin();
    chk("R3 done", int'(done), 1);
    chk("R3 sp", int'(sp), int'(msp));
    e_push(8'h5A);
    issue(3'd0, 1'b0, 16'hA55A);
    wait_fin();
    chk("R3 narrow sp", int'(sp), 16'h00FD);

    // R4 pulls
    cur_tag = "R4";
    e_pull();
    issue(3'd1, 1'b0, 16'h0);
    wait_fin();
    chk("R4 narrow pull", int'(pull_data), 16'h005A);
    e_pull(); e_pull();
    issue(3'd1, 1'b1, 16'h0);
    wait_fin();
    chk("R4 wide pull", int'(pull_data), 16'hBEEF);
    chk("R4 sp", int'(sp), 16'h0100);

    // R5 R6 R7 break entry
    cur_tag = "R5";
    cpu_pc = 16'h4321; cpu_pb = 8'h7E; cpu_p = 8'h09;
    e_entry(16'hFFE6);
    issue(3'd2, 1'b0, 16'h0);
    wait_fin();
    check_redir("R7 brk", 16'h9000, 8'h00, 8'h05, 3'd4);

    // R9 return
    cur_tag = "R9";
    e_pull(); e_pull(); e_pull(); e_pull();
    issue(3'd4, 1'b0, 16'h0);
    wait_fin();
    check_redir("R9", 16'h4321, 8'h7E, 8'h09, 3'd4);
    chk("R9 sp restored", int'(sp), 16'h0100);

    // R6 coprocessor
    cur_tag = "R6";
    cpu_pc = 16'h1000; cpu_pb = 8'h01; cpu_p = 8'h00;
    e_entry(16'hFFE4);
    issue(3'd3, 1'b0, 16'h0);
    wait_fin();
    check_redir("R6 cop", 16'h8040, 8'h00, 8'h04, 3'd5);
    msp = 16'h0100;
    e_pull(); e_pull(); e_pull(); e_pull();
    msp = 16'h00FC;
    e_pull(); e_pull(); e_pull(); e_pull();
    expq.delete();
    e_pull(); e_pull(); e_pull(); e_pull();
    msp = 16'h00FC; expq.delete();
    e_pull(); e_pull(); e_pull(); e_pull();
    issue(3'd4, 1'b0, 16'h0);
    wait_fin();
    chk("R9 cop return pc", int'(new_pc), 16'h1000);

    // R8 masked IRQ does not block commands
    cur_tag = "R8";
    cpu_p = 8'h04; irq_req = 1'b1;
    e_push(8'h11);
    issue(3'd0, 1'b0, 16'h0011);
    wait_fin();
    chk("R8 masked irq push done", int'(done), 1);
    e_pull();
    issue(3'd1, 1'b0, 16'h0);
    wait_fin();
    chk("R8 masked irq pull", int'(pull_data), 16'h0011);
    irq_req = 1'b0;

    // R8 priority abort > NMI > IRQ
    @(negedge clk);
    cpu_p = 8'h00; cpu_pc = 16'h2222; cpu_pb = 8'h03;
    e_entry(16'hFFE8);
    abort_req = 1'b1; nmi_req = 1'b1; irq_req = 1'b1;
    wait_fin();
    check_redir("R8 abort first", 16'hA000, 8'h00, 8'h04, 3'd1);
    abort_req = 1'b0;
    e_entry(16'hFFEA);
    wait_fin();
    check_redir("R8 nmi second", 16'hB000, 8'h00, 8'h04, 3'd2);
    nmi_req = 1'b0;
    e_entry(16'hFFEE);
    wait_fin();
    check_redir("R6 irq vector", 16'hC000, 8'h00, 8'h04, 3'd3);
    irq_req = 1'b0;

    // R10 wait with masked IRQ
    cur_tag = "R10";
    cpu_p = 8'h04;
    issue(3'd5, 1'b0, 16'h0);
    repeat (4) @(negedge clk);
    chk("R10 waiting", int'(waiting), 1);
    chk("R10 not ready", int'(cmd_ready), 0);
    irq_req = 1'b1;
    wait_fin();
    chk("R10 masked wake done", int'(done), 1);
    chk("R10 masked wake no redirect", int'(redirect), 0);
    irq_req = 1'b0;

    // R10 wait with unmasked IRQ
    cpu_p = 8'h08; cpu_pc = 16'h3456; cpu_pb = 8'h00;
    issue(3'd5, 1'b0, 16'h0);
    repeat (3) @(negedge clk);
    chk("R10 waiting again", int'(waiting), 1);
    e_entry(16'hFFEE);
    irq_req = 1'b1;
    wait_fin();
    check_redir("R10 irq entry", 16'hC000, 8'h00, 8'h04, 3'd3);
    irq_req = 1'b0;

    // R11 reserved op
    cur_tag = "R11";
    issue(3'd6, 1'b0, 16'h0);
    wait_fin();
    chk("R11 done", int'(done), 1);
    chk("R11 sp unchanged", int'(sp), int'(msp));
    issue(3'd7, 1'b0, 16'h0);
    wait_fin();
    chk("R11 op7 done", int'(done), 1);

    repeat (5) @(negedge clk);
    chk("R2 queue drained", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule